// File: doc/BRIEF.md
# Double-Buffered Serial Transmit Path

This block takes data words written by a host or DMA engine through a register-write interface and sends them one bit per clock on a serial data output. There are two storage stages. The first is a host-writable data register with a low half and a high half. The second is a shift register that feeds the output pin. A word of 8, 12, 16, 20, 24 or 32 bits is built from the two halves. For words longer than 16 bits, the host writes the high half first. Writing the low half always commits the complete word.

A committed word moves into the shift register in one of two ways. If the shift register is empty, the move happens at once. If a word is still being sent, the move happens on the exact clock edge that puts that word's final bit on the pin. A loaded word does not start until a frame sync is sampled. It then leaves most significant bit first, beginning in the next cycle. If a frame sync is sampled just as the final bit appears on the pin, the next loaded word follows with no gap.

A frame sync that finds nothing to send raises a sticky underflow flag, and the output stays low. An optional logarithmic compressor, selectable between two standard telephony laws, can turn the 16-bit value in the low half into an 8-bit code. That code is then sent as an 8-bit word.

Top module: `sertx_path`

## Requirements
- R1: After reset, and again after a reset applied in the middle of a word, sdo is 0, tx_ready is 1 and underflow is 0.
- R2: A write to the low half with wr_lo makes tx_ready 0 in the next cycle. If the shift register is empty, the word is copied on the following edge, so tx_ready is 1 two cycles after the write.
- R3: len_sel selects the word length: 0→8, 1→12, 2→16, 3→20, 4→24, 5/6/7→32 bits. A word longer than 16 bits is {high half, low half}, and only its low N bits are sent.
- R4: For word lengths of 16 bits or less, the high half has no effect: only the low N bits of the low half are sent.
- R5: Bits leave MSB first, one per cycle. The first bit is on sdo in the cycle after the edge that samples fsync. sdo is 0 in every cycle in which no word is being sent.
- R6: A word held in the shift register is not sent until fsync is sampled. Until then, sdo stays 0 however long it waits.
- R7: If a new word is committed while another is being sent, tx_ready stays 0 until the edge that puts the final bit on sdo. It is 1 in that final-bit cycle.
- R8: If fsync is sampled during the final-bit cycle and a next word is loaded, that word's MSB appears in the very next cycle.
- R9: fsync while a word is being sent has no effect on that word.
- R10: fsync with an empty shift register and no word being sent sets underflow in the next cycle and leaves sdo at 0. underflow holds until the next wr_lo clears it.
- R11: With comp_en=1 and comp_law=0, the low half is encoded with the North-American law (14-bit magnitude range, bias 33, all code bits inverted) and sent as an 8-bit word regardless of len_sel. Examples: 0x0000→0xFF, 0x7FFF→0x80, 0x8000→0x00, 0x0100→0xE7, 0xFF00→0x67, 0x1000→0xAF.
- R12: With comp_en=1 and comp_law=1, the European law is used (13-bit range, even bits inverted) and the result is sent as an 8-bit word. Examples: 0x0000→0xD5, 0x7FFF→0xAA, 0x8000→0x2A, 0x0100→0xC5, 0xFF00→0x5A, 0x1000→0x85.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_hi | input | 1 | Write strobe for the high half of the data register |
| wr_lo | input | 1 | Write strobe for the low half; commits the word |
| wr_data | input | HALF_W | Write data for either half |
| len_sel | input | 3 | Word length code, sampled when the word is copied |
| comp_en | input | 1 | Compression enable, sampled when the word is copied |
| comp_law | input | 1 | Compression law: 0 North-American, 1 European |
| fsync | input | 1 | Transmit frame sync |
| sdo | output | 1 | Serial data output |
| tx_ready | output | 1 | Data register has been copied and may be rewritten |
| underflow | output | 1 | Sticky flag: fsync found nothing to send |

## Verification
A wrong bit count or a wrong shift alignment shows on sdo within one word time. The sent word comes out truncated, shifted, or followed by stray bits where the bench expects a low level. A wrong busy or pending flag moves the rising edge of tx_ready, or the start of a back-to-back word, by a cycle or more. The bench samples both in the exact final-bit cycle, so the error is seen within one word. A wrong compression segment or mantissa selection shows as a wrong 8-bit code in the first compressed word sent. The table covers both laws at zero, at both clipping extremes and at mid-range values.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int HALF_W = 16;
    localparam int LEN_CODE_W = 3;
    localparam int CODE_W = 8;
    localparam int LOG_IN_W = 14;

    typedef enum logic {
        LAW_NA = 1'b0,
        LAW_EU = 1'b1
    } law_e;

    typedef struct packed {
        logic en;
        law_e law;
    } comp_cfg_t;

    // word length in bits for a length code; codes above 4 mean 32
    function automatic logic [5:0] len_bits(input logic [LEN_CODE_W-1:0] sel);
        logic [5:0] n;
        case (sel)
            3'd0:    n = 6'd8;
            3'd1:    n = 6'd12;
            3'd2:    n = 6'd16;
            3'd3:    n = 6'd20;
            3'd4:    n = 6'd24;
            default: n = 6'd32;
        endcase
        return n;
    endfunction

    // North-American law: input is linear[15:2] (14-bit signed)
    function automatic logic [CODE_W-1:0] enc_na(input logic [13:0] v);
        logic [16:0] p;
        logic [16:0] mag;
        logic [16:0] sh;
        logic [7:0]  mask;
        logic [3:0]  seg;
        p = {{3{v[13]}}, v};
        if (v[13]) begin
            mask = 8'h7F;
            mag  = 17'd0 - p;
        end else begin
            mask = 8'hFF;
            mag  = p;
        end
        if (mag > 17'd8159) mag = 17'd8159;
        mag = mag + 17'd33;
        seg = 4'd8;
        for (int i = 7; i >= 0; i--) begin
            if (mag < (17'd64 << i)) seg = 4'(i);
        end
        if (seg == 4'd8) return 8'h7F ^ mask;
        sh = mag >> (seg + 4'd1);
        return {1'b0, seg[2:0], sh[3:0]} ^ mask;
    endfunction

    // European law: input is linear[15:3] (13-bit signed)
    function automatic logic [CODE_W-1:0] enc_eu(input logic [12:0] v);
        logic [16:0] p;
        logic [16:0] mag;
        logic [16:0] sh;
        logic [7:0]  mask;
        logic [3:0]  seg;
        p = {{4{v[12]}}, v};
        if (v[12]) begin
            mask = 8'h55;
            mag  = ~p;
        end else begin
            mask = 8'hD5;
            mag  = p;
        end
        seg = 4'd8;
        for (int i = 7; i >= 0; i--) begin
            if (mag < (17'd32 << i)) seg = 4'(i);
        end
        if (seg == 4'd8) return 8'h7F ^ mask;
        if (seg < 4'd2) sh = mag >> 1;
        else            sh = mag >> seg;
        return {1'b0, seg[2:0], sh[3:0]} ^ mask;
    endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              take,
    output logic [HALF_W-1:0] hold_hi,
    output logic [HALF_W-1:0] hold_lo,
    output logic              pend,
    output logic              tx_ready
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_hi  <= '0;
            hold_lo  <= '0;
            pend     <= 1'b0;
            tx_ready <= 1'b1;
        end else begin
            if (wr_hi) hold_hi <= wr_data;
            if (wr_lo) begin
                hold_lo  <= wr_data;
                pend     <= 1'b1;
                tx_ready <= 1'b0;
            end else if (take) begin
                pend     <= 1'b0;
                tx_ready <= 1'b1;
            end
        end
    end

    AST_WRITE_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> (!tx_ready && pend)); // R2

    AST_COPY_SETS_READY: assert property (@(posedge clk) disable iff (rst)
        (take && !wr_lo) |=> (tx_ready && !pend)); // R7

endmodule

// File: rtl/sertx_compand.sv
module sertx_compand
    import sertx_pkg::*;
(
    input  logic [LOG_IN_W-1:0] lin_top,
    input  law_e                law,
    output logic [CODE_W-1:0]   code
);

    always_comb begin
        if (law == LAW_EU) code = enc_eu(lin_top[LOG_IN_W-1:1]);
        else               code = enc_na(lin_top);
    end

endmodule

// File: rtl/sertx_format.sv
module sertx_format
    import sertx_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int WORD_W = 2 * HALF_W,
    parameter int CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic [HALF_W-1:0]     hold_hi,
    input  logic [HALF_W-1:0]     hold_lo,
    input  logic [LEN_CODE_W-1:0] len_sel,
    input  logic                  comp_on,
    input  logic [CODE_W-1:0]     code,
    output logic [WORD_W-1:0]     word_aligned,
    output logic [CNT_W-1:0]      word_bits
);

    logic [WORD_W-1:0] raw;

    always_comb begin
        if (comp_on) word_bits = CNT_W'(CODE_W);
        else         word_bits = CNT_W'(len_bits(len_sel));

        if (comp_on)                         raw = WORD_W'(code);
        else if (word_bits > CNT_W'(HALF_W)) raw = {hold_hi, hold_lo};
        else                                 raw = WORD_W'(hold_lo);

        // left-align so the word's MSB sits at the top of the shifter
        word_aligned = raw << (CNT_W'(WORD_W) - word_bits);
    end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
    parameter int WORD_W = 32,
    parameter int CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pend,
    input  logic [WORD_W-1:0] next_word,
    input  logic [CNT_W-1:0]  next_bits,
    input  logic              fsync,
    input  logic              clr_under,
    output logic              take,
    output logic              sdo,
    output logic              underflow
);

    logic [WORD_W-1:0] sr;
    logic [CNT_W-1:0]  left;
    logic [CNT_W-1:0]  nbits_q;
    logic              full;
    logic              active;
    logic              last_edge;
    logic              start;

    assign last_edge = active && (left == CNT_W'(1));
    assign start     = fsync && !active && full;
    assign take      = pend && (!full || last_edge);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr        <= '0;
            left      <= '0;
            nbits_q   <= '0;
            full      <= 1'b0;
            active    <= 1'b0;
            sdo       <= 1'b0;
            underflow <= 1'b0;
        end else begin
            if (start) begin
                sdo    <= sr[WORD_W-1];
                sr     <= sr << 1;
                left   <= nbits_q - CNT_W'(1);
                active <= 1'b1;
            end else if (active) begin
                sdo  <= sr[WORD_W-1];
                sr   <= sr << 1;
                left <= left - CNT_W'(1);
                if (left == CNT_W'(1)) active <= 1'b0;
            end else begin
                sdo <= 1'b0;
            end

            if (take) begin
                sr      <= next_word;
                nbits_q <= next_bits;
                full    <= 1'b1;
            end else if (last_edge) begin
                full <= 1'b0;
            end

            if (fsync && !active && !full) underflow <= 1'b1;
            else if (clr_under)            underflow <= 1'b0;
        end
    end

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        (!active && !(fsync && full)) |=> !sdo); // R5

    AST_WAIT_FOR_SYNC: assert property (@(posedge clk) disable iff (rst)
        (!active && !fsync) |=> !active); // R6

    AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (rst)
        (fsync && !active && !full) |=> underflow); // R10

    AST_NO_TRUNCATION: assert property (@(posedge clk) disable iff (rst)
        (active && left > CNT_W'(1)) |=> (active && left == $past(left) - CNT_W'(1))); // R9

endmodule

// File: rtl/sertx_path.sv
module sertx_path
    import sertx_pkg::*;
#(
    parameter int HALF_W     = sertx_pkg::HALF_W,
    parameter bit COMPAND_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [2:0]        len_sel,
    input  logic              comp_en,
    input  logic              comp_law,
    input  logic              fsync,
    output logic              sdo,
    output logic              tx_ready,
    output logic              underflow
);

    localparam int WORD_W = 2 * HALF_W;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    logic [HALF_W-1:0] hold_hi;
    logic [HALF_W-1:0] hold_lo;
    logic              pend;
    logic              take;
    logic [CODE_W-1:0] code;
    logic [WORD_W-1:0] word_aligned;
    logic [CNT_W-1:0]  word_bits;
    comp_cfg_t         cfg;

    assign cfg.en  = COMPAND_EN && comp_en;
    assign cfg.law = law_e'(comp_law);

    sertx_hold #(.HALF_W(HALF_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .wr_hi    (wr_hi),
        .wr_lo    (wr_lo),
        .wr_data  (wr_data),
        .take     (take),
        .hold_hi  (hold_hi),
        .hold_lo  (hold_lo),
        .pend     (pend),
        .tx_ready (tx_ready)
    );

    generate
        if (COMPAND_EN) begin : g_comp
            sertx_compand u_comp (
                .lin_top (hold_lo[HALF_W-1 -: LOG_IN_W]),
                .law     (cfg.law),
                .code    (code)
            );
        end else begin : g_nocomp
            assign code = '0;
        end
    endgenerate

    sertx_format #(
        .HALF_W (HALF_W),
        .WORD_W (WORD_W),
        .CNT_W  (CNT_W)
    ) u_fmt (
        .hold_hi      (hold_hi),
        .hold_lo      (hold_lo),
        .len_sel      (len_sel),
        .comp_on      (cfg.en),
        .code         (code),
        .word_aligned (word_aligned),
        .word_bits    (word_bits)
    );

    sertx_shifter #(
        .WORD_W (WORD_W),
        .CNT_W  (CNT_W)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .pend      (pend),
        .next_word (word_aligned),
        .next_bits (word_bits),
        .fsync     (fsync),
        .clr_under (wr_lo),
        .take      (take),
        .sdo       (sdo),
        .underflow (underflow)
    );

endmodule

// File: tb/sertx_path_test.sv
module sertx_path_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 18;

    typedef struct packed {
        logic [2:0]  len;
        logic        comp;
        logic        law;
        logic [15:0] hi;
        logic [15:0] lo;
        logic [31:0] exp;
        logic [5:0]  n;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 1'b0, 1'b0, 16'hFFFF, 16'h12A5, 32'h000000A5, 6'd8},
        '{3'd1, 1'b0, 1'b0, 16'hFFFF, 16'hF3C6, 32'h000003C6, 6'd12},
        '{3'd2, 1'b0, 1'b0, 16'h5555, 16'h8001, 32'h00008001, 6'd16},
        '{3'd3, 1'b0, 1'b0, 16'hABCD, 16'h1234, 32'h000D1234, 6'd20},
        '{3'd4, 1'b0, 1'b0, 16'h00E7, 16'h5A5A, 32'h00E75A5A, 6'd24},
        '{3'd5, 1'b0, 1'b0, 16'hDEAD, 16'hBEEF, 32'hDEADBEEF, 6'd32},
        '{3'd5, 1'b1, 1'b0, 16'hFFFF, 16'h0000, 32'h000000FF, 6'd8},
        '{3'd5, 1'b1, 1'b0, 16'h0000, 16'h7FFF, 32'h00000080, 6'd8},
        '{3'd5, 1'b1, 1'b0, 16'h0000, 16'h8000, 32'h00000000, 6'd8},
        '{3'd5, 1'b1, 1'b0, 16'h0000, 16'h0100, 32'h000000E7, 6'd8},
        '{3'd5, 1'b1, 1'b0, 16'h0000, 16'hFF00, 32'h00000067, 6'd8},
        '{3'd5, 1'b1, 1'b0, 16'h0000, 16'h1000, 32'h000000AF, 6'd8},
        '{3'd5, 1'b1, 1'b1, 16'hFFFF, 16'h0000, 32'h000000D5, 6'd8},
        '{3'd5, 1'b1, 1'b1, 16'h0000, 16'h7FFF, 32'h000000AA, 6'd8},
        '{3'd5, 1'b1, 1'b1, 16'h0000, 16'h8000, 32'h0000002A, 6'd8},
        '{3'd5, 1'b1, 1'b1, 16'h0000, 16'h0100, 32'h000000C5, 6'd8},
        '{3'd5, 1'b1, 1'b1, 16'h0000, 16'hFF00, 32'h0000005A, 6'd8},
        '{3'd5, 1'b1, 1'b1, 16'h0000, 16'h1000, 32'h00000085, 6'd8}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_hi = 1'b0;
    logic        wr_lo = 1'b0;
    logic [15:0] wr_data = '0;
    logic [2:0]  len_sel = 3'd2;
    logic        comp_en = 1'b0;
    logic        comp_law = 1'b0;
    logic        fsync = 1'b0;
    logic        sdo;
    logic        tx_ready;
    logic        underflow;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sertx_path uut (
        .clk       (clk),
        .rst       (rst),
        .wr_hi     (wr_hi),
        .wr_lo     (wr_lo),
        .wr_data   (wr_data),
        .len_sel   (len_sel),
        .comp_en   (comp_en),
        .comp_law  (comp_law),
        .fsync     (fsync),
        .sdo       (sdo),
        .tx_ready  (tx_ready),
        .underflow (underflow)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // at a negedge: pulse fsync, then sample n bits on the following negedges
    task automatic send_collect(input int n, output logic [31:0] got);
        fsync = 1'b1;
        got = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fsync = 1'b0;
            got = {got[30:0], sdo};
        end
    endtask

    task automatic write_lo(input logic [15:0] d);
        wr_lo = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_lo = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] got;
        logic [31:0] got_b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 sdo after reset", 32'(sdo), 32'd0);
        check("R1 tx_ready after reset", 32'(tx_ready), 32'd1);
        check("R1 underflow after reset", 32'(underflow), 32'd0);

        // vector table: length codes, high-half use, both compression laws
        for (int v = 0; v < NVEC; v++) begin
            len_sel  = VECS[v].len;
            comp_en  = VECS[v].comp;
            comp_law = VECS[v].law;
            wr_hi = 1'b1;
            wr_data = VECS[v].hi;
            @(negedge clk);
            wr_hi = 1'b0;
            write_lo(VECS[v].lo);
            check("R2 ready low after write", 32'(tx_ready), 32'd0);
            @(negedge clk);
            check("R2 ready high after copy", 32'(tx_ready), 32'd1);
            send_collect(int'(VECS[v].n), got);
            if (VECS[v].comp && VECS[v].law)
                check("R12 european code", got, VECS[v].exp);
            else if (VECS[v].comp)
                check("R11 north-american code", got, VECS[v].exp);
            else if (VECS[v].n > 6'd16)
                check("R3 long word", got, VECS[v].exp);
            else
                check("R4 short word ignores high half", got, VECS[v].exp);
            @(negedge clk);
            check("R5 sdo low after word", 32'(sdo), 32'd0);
        end
        comp_en = 1'b0;
        len_sel = 3'd2;

        // R6: loaded word waits for frame sync
        write_lo(16'hF00F);
        begin
            logic any_high;
            any_high = 1'b0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (sdo) any_high = 1'b1;
            end
            check("R6 sdo held low without fsync", 32'(any_high), 32'd0);
        end
        send_collect(16, got);
        check("R6 word sent after late fsync", got, 32'h0000F00F);
        @(negedge clk);

        // R7/R8/R9: write during shifting, mid-word fsync, back-to-back
        write_lo(16'hC3A5);
        @(negedge clk);
        fsync = 1'b1;
        got = '0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            fsync = 1'b0;
            wr_lo = 1'b0;
            got = {got[30:0], sdo};
            if (i == 2) begin
                wr_lo = 1'b1;
                wr_data = 16'h5A0F;
            end
            if (i == 3)  check("R7 ready low while busy", 32'(tx_ready), 32'd0);
            if (i == 6)  fsync = 1'b1;
            if (i == 14) check("R7 ready still low before last bit", 32'(tx_ready), 32'd0);
            if (i == 15) begin
                check("R7 ready high in last-bit cycle", 32'(tx_ready), 32'd1);
                fsync = 1'b1;
            end
        end
        check("R9 word unaffected by mid-word fsync", got, 32'h0000C3A5);
        got_b = '0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            fsync = 1'b0;
            got_b = {got_b[30:0], sdo};
        end
        check("R8 back-to-back word", got_b, 32'h00005A0F);
        check("R8 no underflow on back-to-back", 32'(underflow), 32'd0);
        @(negedge clk);

        // R10: underflow
        fsync = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
        check("R10 underflow set", 32'(underflow), 32'd1);
        check("R10 sdo low on underflow", 32'(sdo), 32'd0);
        repeat (3) @(negedge clk);
        check("R10 underflow sticky", 32'(underflow), 32'd1);
        write_lo(16'h0081);
        check("R10 underflow cleared by write", 32'(underflow), 32'd0);
        @(negedge clk);
        send_collect(16, got);
        check("R10 word after underflow", got, 32'h00000081);
        @(negedge clk);

        // R1: reset in the middle of a word
        len_sel = 3'd5;
        write_lo(16'hFFFF);
        @(negedge clk);
        fsync = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
        write_lo(16'hFFFF);
        fsync = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 sdo after mid-word reset", 32'(sdo), 32'd0);
        check("R1 tx_ready after mid-word reset", 32'(tx_ready), 32'd1);
        check("R1 underflow after mid-word reset", 32'(underflow), 32'd0);
        repeat (2) @(negedge clk);
        check("R1 no leftover bits after reset", 32'(sdo), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule